// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block is the software-visible register front end of a four-channel DMA controller. A host reaches it through a byte-wide port with a 4-bit register offset and separate write and read strobes. Each channel has a 16-bit address and a 16-bit count. Both are reached at a single offset as two byte accesses, low byte first. A shared byte-pointer state machine steers those two accesses. A transfer engine reads the live values from the block's output ports and sends updates back through one update port.

Each channel keeps a base copy and a current copy of its address and count. A host write loads both copies. The engine rewrites only the current copy. When a transfer reaches terminal count on a channel with autoinitialize set, the current copies are reloaded from the base copies. The block also holds the command register, a software request bit per channel, the channel mask bits and a status register. Status latches terminal count per channel and shows pending requests.

The byte pointer has two states, `PTR_LO` and `PTR_HI`. On an address or count access it takes the transition TOGGLE: `PTR_LO` goes to `PTR_HI` and `PTR_HI` goes back to `PTR_LO`. On a write to the clear-pointer offset or the master-clear offset it takes the transition FORCE_LO, which lands in `PTR_LO` from either state. In every other cycle it takes the transition HOLD and stays in its current state. Reset enters `PTR_LO`.

Top module: `dma_regbank`

## Requirements
- R1: After reset, all four mask bits are 1, the byte pointer is `PTR_LO`, and the command register, status, software requests, addresses, counts and modes are all zero.
- R2: Channel n's address sits at offset 2n and its count at offset 2n+1, for n = 0 to 3. An access there moves the low byte (data 7:0 of the 16-bit value) when the pointer is `PTR_LO` and the high byte when it is `PTR_HI`. Each such read or write toggles the pointer.
- R3: A write of any value to offset 12 forces the pointer to `PTR_LO`.
- R4: A host write to an address or count byte loads that byte into both the base and current copies. A read returns the byte of the current copy, so a count reads back as the live remaining count minus one.
- R5: A write to offset 10 selects the channel with data bits 1:0. Data bit 2 = 1 sets that channel's mask bit and data bit 2 = 0 clears it.
- R6: A write to offset 14 clears all four mask bits. A write to offset 15 loads mask bit n from data bit n.
- R7: A write to offset 11 selects the channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode (`ch_mode` bits 5:0 = data 7:2). Data bits 3:2 give the direction (01 = device to memory, 10 = memory to device). Data bit 4 enables autoinitialize. Data bits 7:6 give the mode (01 = single, 11 = cascade).
- R8: An engine update without terminal count replaces the current address and count of channel `upd_ch` with `upd_addr` and `upd_cnt`. The base copies are left unchanged.
- R9: An engine update with terminal count sets status bit `upd_ch`. If that channel's autoinitialize bit is set, the current copies are reloaded from the base copies. Otherwise they take the update values, so after a complete transfer the count reads 0xFFFF.
- R10: A read of offset 8 returns status. Bits 3:0 are the latched terminal-count flags of channels 3 to 0, and bits 7:4 are `dreq` OR the software request bits. The read clears bits 3:0 at the end of the read cycle.
- R11: A write to offset 9 selects the channel with data bits 1:0. Data bit 2 = 1 sets that channel's software request bit and data bit 2 = 0 clears it.
- R12: A write to offset 13 sets all mask bits and clears the command register, the latched terminal-count flags and the software requests. It forces the pointer to `PTR_LO` and leaves addresses, counts and modes intact. A read of offset 13 returns zero.
- R13: A write to offset 8 loads the command register, which appears on `cmd_q` from the next cycle.
- R14: If a host write to a channel's address or count register and an engine update for that same channel fall in the same cycle, the host write takes effect and the update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_off | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; read side effects take effect at the clock edge |
| rd_data | output | 8 | Read data, valid while rd_en is high, zero otherwise |
| dreq | input | 4 | Pending hardware requests, shown in status bits 7:4 |
| upd_valid | input | 1 | Engine update strobe |
| upd_ch | input | 2 | Channel being updated |
| upd_tc | input | 1 | Update marks terminal count |
| upd_addr | input | 16 | New current address |
| upd_cnt | input | 16 | New current count |
| ch_addr | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| ch_cnt | output | 64 | Current counts, channel n at bits 16n+15:16n |
| ch_mode | output | 24 | Modes, channel n at bits 6n+5:6n |
| ch_mask | output | 4 | Mask bit per channel |
| cmd_q | output | 8 | Command register |

## Verification
The bench moves the byte pointer into `PTR_HI` and then writes the clear-pointer or master-clear offset. A design that ignores FORCE_LO returns the high byte where the low byte is expected. It reads status twice after a terminal count. A design that never clears the flags returns the same value both times, and one that clears on the wrong cycle loses the first value. It sends terminal count to one channel with autoinitialize and one without. Swapping the two cases shows up as wrong current values on the port, and the count of the non-autoinitialize channel must read back as 0xFFFF. It also puts a host address write and an engine update to the same channel in one cycle. A design with the wrong priority shows the engine's address on `ch_addr`.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
    localparam int NUM_CH = 4;
    localparam int REG_W  = 8;
    localparam int MODE_W = 6;
    localparam int OFF_W  = 4;

    localparam logic [OFF_W-1:0] OFF_CMD     = 4'd8;
    localparam logic [OFF_W-1:0] OFF_REQ     = 4'd9;
    localparam logic [OFF_W-1:0] OFF_SMASK   = 4'd10;
    localparam logic [OFF_W-1:0] OFF_MODE    = 4'd11;
    localparam logic [OFF_W-1:0] OFF_CLRPTR  = 4'd12;
    localparam logic [OFF_W-1:0] OFF_MCLR    = 4'd13;
    localparam logic [OFF_W-1:0] OFF_CLRMASK = 4'd14;
    localparam logic [OFF_W-1:0] OFF_ALLMASK = 4'd15;

    // position of autoinitialize inside the stored 6-bit mode (data bit 4)
    localparam int MODE_AUTO_BIT = 2;

    typedef enum logic {PTR_LO = 1'b0, PTR_HI = 1'b1} ptr_state_e;
endpackage

// File: rtl/dmarb_byteptr.sv
module dmarb_byteptr
    import dmarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic force_lo,
    output logic hi_sel
);
    ptr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (force_lo) begin
            state_d = PTR_LO;                 // FORCE_LO
        end else if (access) begin
            unique case (state_q)             // TOGGLE
                PTR_LO: state_d = PTR_HI;
                PTR_HI: state_d = PTR_LO;
            endcase
        end
    end

    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan
    import dmarb_pkg::*;
#(
    parameter int BYTE_W = REG_W,
    parameter int MW     = MODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_we,
    input  logic                cnt_we,
    input  logic                hi_sel,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                mode_we,
    input  logic [MW-1:0]       mode_in,
    input  logic                upd_en,
    input  logic                upd_tc,
    input  logic [2*BYTE_W-1:0] upd_addr,
    input  logic [2*BYTE_W-1:0] upd_cnt,
    output logic [2*BYTE_W-1:0] cur_addr,
    output logic [2*BYTE_W-1:0] cur_cnt,
    output logic [MW-1:0]       mode_q
);
    localparam int VW = 2 * BYTE_W;

    logic [VW-1:0] base_addr, base_cnt;
    logic          host_hit;
    logic          reload;

    assign host_hit = addr_we | cnt_we;
    assign reload   = upd_tc & mode_q[MODE_AUTO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else if (host_hit) begin
            if (addr_we) begin
                if (hi_sel) begin
                    base_addr[VW-1:BYTE_W] <= wdata;
                    cur_addr[VW-1:BYTE_W]  <= wdata;
                end else begin
                    base_addr[BYTE_W-1:0] <= wdata;
                    cur_addr[BYTE_W-1:0]  <= wdata;
                end
            end
            if (cnt_we) begin
                if (hi_sel) begin
                    base_cnt[VW-1:BYTE_W] <= wdata;
                    cur_cnt[VW-1:BYTE_W]  <= wdata;
                end else begin
                    base_cnt[BYTE_W-1:0] <= wdata;
                    cur_cnt[BYTE_W-1:0]  <= wdata;
                end
            end
        end else if (upd_en) begin
            cur_addr <= reload ? base_addr : upd_addr;
            cur_cnt  <= reload ? base_cnt  : upd_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_in;
    end
endmodule

// File: rtl/dmarb_ctrl.sv
module dmarb_ctrl
    import dmarb_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NCH-1:0]   dreq,
    input  logic [NCH-1:0]   tc_set,
    output logic [NCH-1:0]   mask_q,
    output logic [REG_W-1:0] cmd_q,
    output logic [2*NCH-1:0] status
);
    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0] tc_q, sreq_q;
    logic           mclr, stat_rd;
    logic [CHW-1:0] sel;

    assign mclr    = wr_en && reg_off == OFF_MCLR;
    assign stat_rd = rd_en && reg_off == OFF_CMD;
    assign sel     = wr_data[CHW-1:0];
    assign status  = {dreq | sreq_q, tc_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            cmd_q  <= '0;
            sreq_q <= '0;
            tc_q   <= '0;
        end else if (mclr) begin
            mask_q <= '1;
            cmd_q  <= '0;
            sreq_q <= '0;
            tc_q   <= '0;
        end else begin
            tc_q <= (stat_rd ? '0 : tc_q) | tc_set;
            if (wr_en) begin
                unique case (reg_off)
                    OFF_CMD:     cmd_q       <= wr_data;
                    OFF_REQ:     sreq_q[sel] <= wr_data[2];
                    OFF_SMASK:   mask_q[sel] <= wr_data[2];
                    OFF_CLRMASK: mask_q      <= '0;
                    OFF_ALLMASK: mask_q      <= wr_data[NCH-1:0];
                    default:     ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dmarb_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int BW  = REG_W,
    parameter int MW  = MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_off,
    input  logic              wr_en,
    input  logic [BW-1:0]     wr_data,
    input  logic              rd_en,
    output logic [BW-1:0]     rd_data,
    input  logic [NCH-1:0]    dreq,
    input  logic              upd_valid,
    input  logic [1:0]        upd_ch,
    input  logic              upd_tc,
    input  logic [2*BW-1:0]   upd_addr,
    input  logic [2*BW-1:0]   upd_cnt,
    output logic [NCH*2*BW-1:0] ch_addr,
    output logic [NCH*2*BW-1:0] ch_cnt,
    output logic [NCH*MW-1:0] ch_mode,
    output logic [NCH-1:0]    ch_mask,
    output logic [BW-1:0]     cmd_q
);
    localparam int VW = 2 * BW;

    logic              ptr_hi;
    logic              val_acc;
    logic [1:0]        acc_ch;
    logic [NCH-1:0]    tc_set;
    logic [2*NCH-1:0]  status;
    logic [VW-1:0]     cur_a [NCH];
    logic [VW-1:0]     cur_c [NCH];
    logic [VW-1:0]     rd_val;

    assign val_acc = (wr_en | rd_en) & ~reg_off[3];
    assign acc_ch  = reg_off[2:1];

    dmarb_byteptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (val_acc),
        .force_lo (wr_en && (reg_off == OFF_CLRPTR || reg_off == OFF_MCLR)),
        .hi_sel   (ptr_hi)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit       = wr_en && !reg_off[3] && acc_ch == n;
        assign tc_set[n] = upd_valid && upd_tc && upd_ch == n;

        dmarb_chan #(.BYTE_W(BW), .MW(MW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_we  (hit && !reg_off[0]),
            .cnt_we   (hit && reg_off[0]),
            .hi_sel   (ptr_hi),
            .wdata    (wr_data),
            .mode_we  (wr_en && reg_off == OFF_MODE && wr_data[1:0] == n),
            .mode_in  (wr_data[BW-1:BW-MW]),
            .upd_en   (upd_valid && upd_ch == n),
            .upd_tc   (upd_tc),
            .upd_addr (upd_addr),
            .upd_cnt  (upd_cnt),
            .cur_addr (cur_a[n]),
            .cur_cnt  (cur_c[n]),
            .mode_q   (ch_mode[n*MW +: MW])
        );

        assign ch_addr[n*VW +: VW] = cur_a[n];
        assign ch_cnt[n*VW +: VW]  = cur_c[n];
    end

    dmarb_ctrl #(.NCH(NCH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .reg_off (reg_off),
        .wr_data (wr_data),
        .dreq    (dreq),
        .tc_set  (tc_set),
        .mask_q  (ch_mask),
        .cmd_q   (cmd_q),
        .status  (status)
    );

    always_comb begin
        rd_val  = reg_off[0] ? cur_c[acc_ch] : cur_a[acc_ch];
        rd_data = '0;
        if (rd_en) begin
            if (!reg_off[3])             rd_data = ptr_hi ? rd_val[VW-1:BW] : rd_val[BW-1:0];
            else if (reg_off == OFF_CMD) rd_data = status;
        end
    end
endmodule

// File: rtl/dmarb_chk.sv
module dmarb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_off,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic        upd_valid,
    input logic [1:0]  upd_ch,
    input logic        upd_tc,
    input logic [15:0] upd_addr,
    input logic [63:0] ch_addr,
    input logic [3:0]  ch_mask,
    input logic [7:0]  cmd_q,
    input logic        ptr_hi
);
    logic        sm_q, up_q;
    logic [1:0]  sm_ch, up_ch;
    logic        sm_val;
    logic [15:0] up_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sm_q <= 1'b0; sm_ch <= '0; sm_val <= 1'b0;
            up_q <= 1'b0; up_ch <= '0; up_addr <= '0;
        end else begin
            sm_q    <= wr_en && reg_off == 4'd10;
            sm_ch   <= wr_data[1:0];
            sm_val  <= wr_data[2];
            up_q    <= upd_valid && !upd_tc &&
                       !(wr_en && !reg_off[3] && reg_off[2:1] == upd_ch);
            up_ch   <= upd_ch;
            up_addr <= upd_addr;
        end
    end

    assert_clrptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd12) |=> !ptr_hi);

    assert_single_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sm_q |-> ch_mask[sm_ch] == sm_val);

    assert_clear_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd14) |=> ch_mask == 4'h0);

    assert_engine_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> ch_addr[up_ch*16 +: 16] == up_addr);

    assert_master_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd13) |=> (ch_mask == 4'hF && cmd_q == 8'h00 && !ptr_hi));

    assert_cmd_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == 4'd8) |=> cmd_q == $past(wr_data));
endmodule

bind dma_regbank dmarb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_off   (reg_off),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .upd_valid (upd_valid),
    .upd_ch    (upd_ch),
    .upd_tc    (upd_tc),
    .upd_addr  (upd_addr),
    .ch_addr   (ch_addr),
    .ch_mask   (ch_mask),
    .cmd_q     (cmd_q),
    .ptr_hi    (ptr_hi)
);

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_off = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  dreq = '0;
    logic        upd_valid = 1'b0, upd_tc = 1'b0;
    logic [1:0]  upd_ch = '0;
    logic [15:0] upd_addr = '0, upd_cnt = '0;
    logic [63:0] ch_addr, ch_cnt;
    logic [23:0] ch_mode;
    logic [3:0]  ch_mask;
    logic [7:0]  cmd_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .dreq(dreq),
        .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_tc(upd_tc),
        .upd_addr(upd_addr), .upd_cnt(upd_cnt), .ch_addr(ch_addr),
        .ch_cnt(ch_cnt), .ch_mode(ch_mode), .ch_mask(ch_mask), .cmd_q(cmd_q)
    );

    typedef struct packed {
        logic       is_rd;
        logic [3:0] off;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd12, 8'h00, 8'h00, 4'd3},   // R3 pointer to low
        '{1'b0, 4'd0,  8'h34, 8'h00, 4'd2},   // R2 ch0 addr low
        '{1'b0, 4'd0,  8'h12, 8'h00, 4'd2},   // R2 ch0 addr high
        '{1'b0, 4'd3,  8'hFF, 8'h00, 4'd2},   // R2 ch1 count low
        '{1'b0, 4'd3,  8'h00, 8'h00, 4'd2},   // R2 ch1 count high
        '{1'b1, 4'd0,  8'h00, 8'h34, 4'd4},   // R4 readback
        '{1'b1, 4'd0,  8'h00, 8'h12, 4'd4},
        '{1'b1, 4'd3,  8'h00, 8'hFF, 4'd4},
        '{1'b1, 4'd3,  8'h00, 8'h00, 4'd4},
        '{1'b1, 4'd0,  8'h00, 8'h34, 4'd2},   // pointer now high
        '{1'b0, 4'd12, 8'h5A, 8'h00, 4'd3},   // R3 clear from high
        '{1'b1, 4'd0,  8'h00, 8'h34, 4'd3},   // low byte again
        '{1'b0, 4'd13, 8'h00, 8'h00, 4'd12},  // R12 master clear from high
        '{1'b1, 4'd0,  8'h00, 8'h34, 4'd12},  // R12 pointer low, addr kept
        '{1'b1, 4'd0,  8'h00, 8'h12, 4'd12},
        '{1'b0, 4'd9,  8'h06, 8'h00, 4'd11},  // R11 soft request ch2
        '{1'b1, 4'd8,  8'h00, 8'h40, 4'd11},
        '{1'b0, 4'd9,  8'h02, 8'h00, 4'd11},  // R11 withdraw
        '{1'b1, 4'd8,  8'h00, 8'h00, 4'd10},
        '{1'b1, 4'd13, 8'h00, 8'h00, 4'd12},  // R12 read of offset 13
        '{1'b0, 4'd8,  8'hA5, 8'h00, 4'd13}   // R13 command load
    };

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_off = off; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        reg_off = off; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic upd(input logic [1:0] ch, input logic tc,
                       input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        upd_ch = ch; upd_tc = tc; upd_addr = a; upd_cnt = c; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; upd_tc = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ch_mask, 16'h000F, "R1 masks");
        check(cmd_q, 16'h0000, "R1 command");
        check(ch_addr[15:0], 16'h0000, "R1 address");
        rd(4'd8, rv); check(rv, 8'h00, "R1 status");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) begin
                rd(VEC[i].off, rv);
                n_chk++;
                if (rv !== VEC[i].exp) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d: got %h expected %h",
                             VEC[i].req, i, rv, VEC[i].exp);
                end
            end else begin
                wr(VEC[i].off, VEC[i].data);
            end
        end
        check(cmd_q, 16'h00A5, "R13 command port");

        // R5 single mask
        wr(4'd10, 8'h01); check(ch_mask, 16'h000D, "R5 unmask ch1");
        wr(4'd10, 8'h05); check(ch_mask, 16'h000F, "R5 mask ch1");
        // R6 clear all / write all
        wr(4'd14, 8'hFF); check(ch_mask, 16'h0000, "R6 clear all");
        wr(4'd15, 8'h0A); check(ch_mask, 16'h000A, "R6 write all");

        // R7 mode: ch2, device to memory, autoinit, single
        wr(4'd11, 8'h56); check(ch_mode[17:12], 16'h0015, "R7 mode ch2");

        // R8 engine update on ch2
        wr(4'd4, 8'h00); wr(4'd4, 8'h40); wr(4'd5, 8'h03); wr(4'd5, 8'h00);
        upd(2'd2, 1'b0, 16'h4001, 16'h0002);
        check(ch_addr[47:32], 16'h4001, "R8 addr");
        check(ch_cnt[47:32], 16'h0002, "R8 count");
        rd(4'd5, rv); check(rv, 8'h02, "R4 live count low");
        rd(4'd5, rv); check(rv, 8'h00, "R4 live count high");

        // R9 terminal count with autoinit reloads base
        upd(2'd2, 1'b1, 16'h4004, 16'hFFFF);
        check(ch_addr[47:32], 16'h4000, "R9 autoinit addr");
        check(ch_cnt[47:32], 16'h0003, "R9 autoinit count");
        rd(4'd8, rv); check(rv, 8'h04, "R10 tc flag");
        rd(4'd8, rv); check(rv, 8'h00, "R10 cleared by read");

        // R9 terminal count without autoinit: ch1 memory to device, single
        wr(4'd11, 8'h49);
        upd(2'd1, 1'b1, 16'h0100, 16'hFFFF);
        check(ch_cnt[31:16], 16'hFFFF, "R9 final count");
        rd(4'd3, rv); check(rv, 8'hFF, "R9 count low");
        rd(4'd3, rv); check(rv, 8'hFF, "R9 count high");
        dreq = 4'b1001;
        rd(4'd8, rv); check(rv, 8'h92, "R10 dreq and tc");
        rd(4'd8, rv); check(rv, 8'h90, "R10 dreq only");
        dreq = 4'b0000;

        // R14 host write beats engine update
        @(negedge clk);
        reg_off = 4'd0; wr_data = 8'h77; wr_en = 1'b1;
        upd_ch = 2'd0; upd_tc = 1'b0; upd_addr = 16'h9999; upd_cnt = 16'h0; upd_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; upd_valid = 1'b0;
        check(ch_addr[15:0], 16'h1277, "R14 host priority");

        // R12 master clear
        wr(4'd8, 8'h3C);
        wr(4'd13, 8'h00);
        check(ch_mask, 16'h000F, "R12 masks set");
        check(cmd_q, 16'h0000, "R12 command cleared");
        check(ch_addr[15:0], 16'h1277, "R12 address kept");
        rd(4'd0, rv); check(rv, 8'h77, "R12 pointer low");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule